// File: doc/BRIEF.md
# Gated non-retriggerable one-shot pulser

This block is a clocked monostable channel. It watches three asynchronous control inputs: an active-low edge trigger, an active-high edge trigger and an active-low clear. When a qualified event arrives, it drives a single active-high pulse `q` and its complement `q_n`. The two triggers gate each other. A falling edge on the low-going trigger fires only while the high-going trigger is high. A rising edge on the high-going trigger fires only while the low-going trigger is low. Either trigger, parked at its inhibiting level, blocks the channel.

The pulse length is a cycle count taken from `pulse_len` in the cycle the pulse begins. While a pulse is running, the channel ignores every trigger edge. A low clear cuts the pulse off at once, without waiting for the clock, and prevents new pulses. An internal arming flag allows a pulse to start on the release of clear. The flag is set whenever the channel is left in an inhibiting state while clear is inactive, and it is spent as soon as any pulse starts.

All three controls cross into the clock domain through two-flop synchronisers, and edges are found on the synchronised values. A device with several channels uses one instance per channel.

Top module: `oneshot_pulser`

## Requirements
- R1: A falling edge on `trig_fall_n` starts a pulse when `trig_rise` is high and `clr_n` is high, provided no pulse is running.
- R2: A rising edge on `trig_rise` starts a pulse when `trig_fall_n` is low and `clr_n` is high, provided no pulse is running.
- R3: While `trig_fall_n` stays high, toggling `trig_rise` never starts a pulse. While `trig_rise` stays low, toggling `trig_fall_n` never starts a pulse.
- R4: Edges on either trigger that arrive while a pulse is running have no effect: that pulse keeps its length and no second pulse follows.
- R5: A low `clr_n` drives `q` low within the same clock period, with no clock edge needed, and ends any running pulse. No pulse starts while the synchronised clear is low.
- R6: A rising edge on `clr_n`, with `trig_fall_n` low and `trig_rise` high, starts a pulse only if the arming flag is set.
- R7: The arming flag becomes set in any cycle where the synchronised clear is high and either `trig_fall_n` is high or `trig_rise` is low. It is cleared when a pulse starts, so a second clear release with no re-arming produces no pulse.
- R8: A pulse lasts exactly `pulse_len` clock cycles, with 0 treated as 1. The value is sampled on the clock edge that starts the pulse, and later changes to `pulse_len` do not alter a running pulse.
- R9: A triggering input change first shows on `q` after the third rising clock edge that follows it. A trigger level held for any length of time yields exactly one pulse.
- R10: During and after reset, `q` is 0 and `q_n` is 1. At all times `q_n` is the complement of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_fall_n | input | 1 | Trigger fired by its falling edge; high inhibits |
| trig_rise | input | 1 | Trigger fired by its rising edge; low inhibits |
| clr_n | input | 1 | Active-low clear; its release can fire when armed |
| pulse_len | input | LEN_W | Pulse length in clock cycles (0 means 1) |
| q | output | 1 | Active-high pulse |
| q_n | output | 1 | Complement of q |

## Verification
A trigger or clear-release change made between edges is due on `q` after the third rising edge that follows it. The pulse then stays high for the sampled length, and a low clear pulls `q` down before the next edge. The bench drives inputs on falling edges. It advances a queue-based reference model on each rising edge and compares `q` and `q_n` 1 ns after that edge, so the expected three-edge delay comes from the queue depth and not from fixed waits. The bench also checks the asynchronous clear 1 ns after clear falls, and at the end of each scenario it checks a count of rising pulse edges against the number that scenario should produce.

// File: rtl/osp_pkg.sv
package osp_pkg;

  // bit 0: low-going trigger, bit 1: high-going trigger, bit 2: clear
  typedef struct packed {
    logic clr;
    logic rise;
    logic fall_n;
  } ctl_t;

  // values held by the synchroniser stages during reset (idle, disarmed)
  localparam ctl_t CTL_RESET = '{clr: 1'b0, rise: 1'b0, fall_n: 1'b1};

  // effective pulse length in cycles
  function automatic int unsigned run_len(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/osp_sync.sv
module osp_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  logic [N-1:0] meta;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i] <= RST[i];
        cur[i]  <= RST[i];
        prev[i] <= RST[i];
      end else begin
        meta[i] <= d[i];
        cur[i]  <= meta[i];
        prev[i] <= cur[i];
      end
    end
  end
endmodule

// File: rtl/osp_qualify.sv
module osp_qualify
  import osp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t cur,
  input  ctl_t prev,
  input  logic start,
  output logic fire,
  output logic arm
);
  logic fall_ev, rise_ev, rel_ev, level_ok, arm_set;

  assign fall_ev  = prev.fall_n & ~cur.fall_n;
  assign rise_ev  = ~prev.rise & cur.rise;
  assign rel_ev   = ~prev.clr & cur.clr;
  assign level_ok = ~cur.fall_n & cur.rise & cur.clr;
  assign arm_set  = (cur.fall_n | ~cur.rise) & cur.clr;
  assign fire     = level_ok & (fall_ev | rise_ev | (rel_ev & arm));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       arm <= 1'b0;
    else if (start)   arm <= 1'b0;
    else if (arm_set) arm <= 1'b1;
  end

  // R7: an inhibiting level under an inactive clear leaves the flag set
  p_arm_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_set && !start) |=> arm);
endmodule

// File: rtl/osp_timer.sv
module osp_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill_n,
  input  logic             fire,
  input  logic [LEN_W-1:0] len,
  output logic             start,
  output logic             busy
);
  logic [LEN_W-1:0] rem;

  assign busy  = (rem != '0);
  assign start = fire & ~busy;

  always_ff @(posedge clk or negedge kill_n) begin
    if (!kill_n)     rem <= '0;
    else if (start)  rem <= LEN_W'(osp_pkg::run_len(32'(len)));
    else if (busy)   rem <= rem - LEN_W'(1);
  end

  // R8: a started pulse loads the sampled length
  p_len_load_r8: assert property (@(posedge clk) disable iff (!rst_n || !kill_n)
    start |=> (32'(rem) == osp_pkg::run_len(32'($past(len)))));

  // R4: a running pulse only counts down, whatever the triggers do
  p_no_retrig_r4: assert property (@(posedge clk) disable iff (!rst_n || !kill_n)
    busy |=> (rem + LEN_W'(1) == $past(rem)));
endmodule

// File: rtl/oneshot_pulser.sv
module oneshot_pulser
  import osp_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_fall_n,
  input  logic             trig_rise,
  input  logic             clr_n,
  input  logic [LEN_W-1:0] pulse_len,
  output logic             q,
  output logic             q_n
);
  ctl_t raw, cur, prev;
  logic fire, arm, start, busy, kill_n;

  assign raw    = '{clr: clr_n, rise: trig_rise, fall_n: trig_fall_n};
  assign kill_n = rst_n & clr_n;

  osp_sync #(.N(3), .RST(CTL_RESET)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .cur(cur), .prev(prev)
  );

  osp_qualify u_qual (
    .clk(clk), .rst_n(rst_n), .cur(cur), .prev(prev),
    .start(start), .fire(fire), .arm(arm)
  );

  osp_timer #(.LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .kill_n(kill_n), .fire(fire),
    .len(pulse_len), .start(start), .busy(busy)
  );

  assign q   = busy;
  assign q_n = ~busy;

  // R5: a synchronised clear that is low never coexists with a pulse
  p_clr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cur.clr |-> !q);

  // R7: starting a pulse spends the arming flag
  p_arm_spent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !arm);

  // R3: a start is only ever seen with both triggers at their firing levels
  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!cur.fall_n && cur.rise && cur.clr));

  // R10: outputs complementary at every edge
  p_compl_r10: assert property (@(posedge clk) q_n != q);
endmodule

// File: tb/tb_oneshot_pulser.sv
module tb_oneshot_pulser;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b1, b = 1'b0, c = 1'b1;
  logic [LW-1:0] len = 8'd4;
  logic q, q_n;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 0;
  string tag = "R10";

  always #2 clk = ~clk;

  oneshot_pulser #(.LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .trig_fall_n(a), .trig_rise(b),
    .clr_n(c), .pulse_len(len), .q(q), .q_n(q_n)
  );

  task automatic chk(input int act, input int exp, input string t);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", t, act, exp, $time);
    end
  endtask

  // reference model: input history queues, remaining count, arming flag
  bit ha[$], hb[$], hc[$];
  int rem = 0;
  bit armed = 0, qprev = 0;

  always @(posedge clk) begin
    bit as, ad, bs, bd, cs, cd, go;
    if (!rst_n) begin
      ha = '{1, 1, 1}; hb = '{0, 0, 0}; hc = '{0, 0, 0};
      rem = 0; armed = 0;
    end else begin
      as = ha[1]; ad = ha[2]; bs = hb[1]; bd = hb[2]; cs = hc[1]; cd = hc[2];
      go = 0;
      if (cs && rem == 0 && !as && bs)
        go = (ad || !bd || (!cd && armed));
      if (!c)            rem = 0;
      else if (go)       rem = (len == 0) ? 1 : int'(len);
      else if (rem > 0)  rem--;
      if (go)                   armed = 0;
      else if ((as || !bs) && cs) armed = 1;
      ha.push_front(a); void'(ha.pop_back());
      hb.push_front(b); void'(hb.pop_back());
      hc.push_front(c); void'(hc.pop_back());
    end
    #1;
    if (rst_n) begin
      chk(int'(q), int'(rem > 0 && c), tag);
      chk(int'(q_n), int'(!(rem > 0 && c)), "R10");
      if (q && !qprev) pulses++;
      qprev = q;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pulses(input int base, input int n, input string t);
    chk(pulses - base, n, t);
  endtask

  initial begin
    int base;
    cyc(3);
    #1;
    chk(int'(q), 0, "R10");
    chk(int'(q_n), 1, "R10");
    @(negedge clk) rst_n = 1'b1;

    // R1: low-going edge with the other trigger high
    tag = "R1"; base = pulses;
    b = 1; cyc(6); len = 5; a = 0; cyc(14);
    expect_pulses(base, 1, "R1");

    // R8: zero length gives one cycle; a length change mid-pulse is ignored
    tag = "R8"; base = pulses;
    a = 1; cyc(4); len = 0; a = 0; cyc(8);
    a = 1; cyc(4); len = 4; a = 0; cyc(4); len = 9; cyc(10);
    expect_pulses(base, 2, "R8");

    // R2 and R9: high-going edge with the other trigger low, held long
    tag = "R2"; base = pulses;
    b = 0; cyc(4); len = 3; b = 1; cyc(3);
    chk(int'(q), 1, "R9");
    cyc(30);
    expect_pulses(base, 1, "R9");

    // R3: inhibiting levels block all triggering
    tag = "R3"; base = pulses;
    a = 1; cyc(4);
    for (int i = 0; i < 4; i++) begin b = ~b; cyc(4); end
    b = 0; cyc(4);
    for (int i = 0; i < 4; i++) begin a = ~a; cyc(4); end
    expect_pulses(base, 0, "R3");

    // R4: edges during a pulse are ignored
    tag = "R4"; base = pulses;
    a = 1; b = 1; cyc(4); len = 20; a = 0; cyc(5);
    a = 1; cyc(2); a = 0; cyc(2); b = 0; cyc(2); b = 1; cyc(2);
    cyc(20);
    expect_pulses(base, 1, "R4");

    // R5: clear cuts a pulse at once and blocks triggers
    tag = "R5"; base = pulses;
    a = 1; cyc(4); len = 30; a = 0; cyc(8);
    chk(int'(q), 1, "R5");
    c = 0; #1;
    chk(int'(q), 0, "R5");
    chk(int'(q_n), 1, "R5");
    cyc(4); a = 1; cyc(3); a = 0; cyc(5);
    tag = "R7";
    c = 1; cyc(10);
    expect_pulses(base, 1, "R5");

    // R6: armed clear release fires; R7: a second release without arming does not
    tag = "R6"; base = pulses;
    len = 6; a = 1; cyc(4); c = 0; cyc(2); a = 0; cyc(4);
    c = 1; cyc(14);
    expect_pulses(base, 1, "R6");
    tag = "R7"; base = pulses;
    c = 0; cyc(4); c = 1; cyc(12);
    expect_pulses(base, 0, "R7");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule